// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 8K words by 9 bits. The host hands it one word at a time through a request/ready handshake. The block then plays out a cycle on the memory pins with every timing minimum met by counting clock cycles. The memory pins are a 13-bit address, a chip-select pair of opposite polarity, active-low output and write strobes, and a 9-bit data bus. The data bus is split into an outgoing word, an incoming word and a drive enable.

Every timing limit enters the block as a nanosecond parameter next to the clock period. Each one is rounded up to whole cycles inside the block. A read holds the chip selected with the output enable low until both the access time and the read cycle time have passed. It then registers the bus word, returns it with a one-clock valid strobe, and waits out the memory's output turn-off before it reports ready again. A write pulls the write strobe low first. It starts driving data only after the memory has had time to release the bus, and it keeps driving for at least the data setup time. It raises the strobe with address and data still held, then stays idle for as long as the write cycle time still needs.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever ready is high, the memory is parked: active-low select high, active-high select low, output enable high, write enable high, data driver off.
- R2: A request is taken only at a rising edge where req and ready are both high. Ready is low from the cycle after acceptance until the cycle is complete. A req pulse while ready is low starts no memory cycle.
- R3: A read holds select active, output enable low and write enable high for RD = max(ceil(t_access/t_clk), ceil(t_rcycle/t_clk), 1) cycles. The bus word is registered at the edge that ends that window.
- R4: rvalid is high for exactly one clock, RD+1 edges after the accepting edge, carrying the word stored at the accepted address.
- R5: During a write, output enable stays high. The data driver switches on only after write enable has been low for WZ = max(ceil(t_wz/t_clk), 1) cycles.
- R6: Write enable stays low for WZ+DRV cycles, where DRV = max(ceil(t_dsetup/t_clk), ceil(t_wpulse/t_clk)-WZ, 1). Data is driven for the last DRV of them, which is never less than the setup count.
- R7: While the chip is selected, the address does not change. Write data stays driven and unchanged for one cycle after write enable rises.
- R8: After output enable rises at the end of a read, the chip stays deselected and undriven for HZ = ceil(t_hz/t_clk) cycles before ready returns. A read therefore occupies RD+HZ+1 negative edges from acceptance until ready is seen.
- R9: The address presented on the memory pins already equals the accepted address in the first cycle the chip is selected.
- R10: A write occupies WZ+DRV+1+REC cycles plus the return to ready, where REC = max(ceil(t_wcycle/t_clk)-(WZ+DRV+1), 0).
- R11: The data driver is never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Host word address |
| wdata | input | 9 | Host write word |
| ready | output | 1 | Controller idle, request may be taken |
| rdata | output | 9 | Registered read word |
| rvalid | output | 1 | One-clock strobe for rdata |
| mem_addr | output | 13 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 9 | Word driven onto the data bus |
| mem_dq_in | input | 9 | Word read from the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The hardest case to provoke is sampling the bus too early. From the ports, a read captured one cycle early looks just like a correct one whenever the memory answers at once. The bench memory model therefore counts the cycles since the output enable fell at a stable address. It returns a fixed garbage pattern until the access count has passed, so an early capture shows up as wrong data. The same model counts write-enable-low and driven cycles up to the rising edge of write enable. It commits the word only at that edge, and it watches the turn-off windows after write enable falls and after output enable rises, so every timing shortfall shows up as a counted violation or a wrong readback.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD, PH_TURN, PH_WZ, PH_WDRV, PH_WHOLD, PH_WREC
  } phase_t;

  // Active-true pin controls; top converts polarities.
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drv;
  } busctl_t;

  // Round nanoseconds up to whole clock cycles.
  function automatic int ns2cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Timer reload for a phase of n cycles.
  function automatic int cnt_of(int n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic busctl_t ctl_of(phase_t p);
    busctl_t c;
    c = '0;
    case (p)
      PH_RD:    begin c.sel = 1'b1; c.oe = 1'b1; end
      PH_WZ:    begin c.sel = 1'b1; c.we = 1'b1; end
      PH_WDRV:  begin c.sel = 1'b1; c.we = 1'b1; c.drv = 1'b1; end
      PH_WHOLD: begin c.sel = 1'b1; c.drv = 1'b1; end
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  // R10: a running phase counter steps down by one each cycle
  p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW     = 2,
  parameter int RD_N   = 2,
  parameter int TURN_N = 1,
  parameter int WZ_N   = 1,
  parameter int WDRV_N = 1,
  parameter int WREC_N = 0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    wr,
  output logic    ready,
  output logic    accept,
  output logic    rd_end,
  output busctl_t ctl
);
  phase_t        phase, phase_nx;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  assign ready  = (phase == PH_IDLE);
  assign accept = req && ready;
  assign rd_end = (phase == PH_RD) && tmr_done;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (req) phase_nx = wr ? PH_WZ : PH_RD;
      PH_RD:    if (tmr_done) phase_nx = (TURN_N > 0) ? PH_TURN : PH_IDLE;
      PH_TURN:  if (tmr_done) phase_nx = PH_IDLE;
      PH_WZ:    if (tmr_done) phase_nx = PH_WDRV;
      PH_WDRV:  if (tmr_done) phase_nx = PH_WHOLD;
      PH_WHOLD: phase_nx = (WREC_N > 0) ? PH_WREC : PH_IDLE;
      PH_WREC:  if (tmr_done) phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  assign tmr_load = (phase_nx != phase);

  always_comb begin
    case (phase_nx)
      PH_RD:   tmr_val = CW'(cnt_of(RD_N));
      PH_TURN: tmr_val = CW'(cnt_of(TURN_N));
      PH_WZ:   tmr_val = CW'(cnt_of(WZ_N));
      PH_WDRV: tmr_val = CW'(cnt_of(WDRV_N));
      PH_WREC: tmr_val = CW'(cnt_of(WREC_N));
      default: tmr_val = '0;
    endcase
  end

  sram_cycle_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // Pin controls are registered from the next phase: glitch-free pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ctl   <= '0;
    end else begin
      phase <= phase_nx;
      ctl   <= ctl_of(phase_nx);
    end
  end

  // R2: accepting a request drops ready on the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R6: write strobe never rises straight out of the release wait
  p_wz_to_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WZ && tmr_done) |=> (ctl.we && ctl.drv));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int AW     = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_end,
  input  logic [DATA_W-1:0] dq_in,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      if (accept) mem_addr <= addr;
      if (accept && wr) dq_out <= wdata;
      if (rd_end) rdata <= dq_in;
      rvalid <= rd_end;
    end
  end

  // R4: read strobe lasts a single clock
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 13,
  parameter int DATA_W  = 9,
  parameter int CLK_NS  = 20,
  parameter int T_AA_NS = 25,
  parameter int T_RC_NS = 25,
  parameter int T_HZ_NS = 12,
  parameter int T_WZ_NS = 10,
  parameter int T_WP_NS = 18,
  parameter int T_DW_NS = 13,
  parameter int T_WC_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int AA_C    = ns2cyc(T_AA_NS, CLK_NS);
  localparam int RC_C    = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_C    = ns2cyc(T_WP_NS, CLK_NS);
  localparam int WC_C    = ns2cyc(T_WC_NS, CLK_NS);
  localparam int RD_N    = max2(max2(AA_C, RC_C), 1);
  localparam int TURN_N  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int WZ_N    = max2(ns2cyc(T_WZ_NS, CLK_NS), 1);
  localparam int WP_REST = (WP_C > WZ_N) ? WP_C - WZ_N : 0;
  localparam int WDRV_N  = max2(max2(ns2cyc(T_DW_NS, CLK_NS), WP_REST), 1);
  localparam int WSPAN   = WZ_N + WDRV_N + 1;
  localparam int WREC_N  = (WC_C > WSPAN) ? WC_C - WSPAN : 0;
  localparam int CNT_MAX = max2(max2(max2(RD_N, TURN_N), max2(WZ_N, WDRV_N)), WREC_N);
  localparam int CW      = max2($clog2(CNT_MAX + 1), 1);

  busctl_t ctl;
  logic    accept, rd_end;

  sram_phase_fsm #(
    .CW(CW), .RD_N(RD_N), .TURN_N(TURN_N),
    .WZ_N(WZ_N), .WDRV_N(WDRV_N), .WREC_N(WREC_N)
  ) i_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .wr     (wr),
    .ready  (ready),
    .accept (accept),
    .rd_end (rd_end),
    .ctl    (ctl)
  );

  sram_datapath #(.AW(AW), .DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .rd_end   (rd_end),
    .dq_in    (mem_dq_in),
    .mem_addr (mem_addr),
    .dq_out   (mem_dq_out),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

  assign mem_ce_n  = !ctl.sel;
  assign mem_ce    = ctl.sel;
  assign mem_oe_n  = !ctl.oe;
  assign mem_we_n  = !ctl.we;
  assign mem_dq_oe = ctl.drv;

  // R1: idle means fully parked pins
  p_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R5: output enable stays off while writing
  p_oe_off_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5: driver turns on only after write enable has already been low
  p_drive_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  // R7: address frozen while selected
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R7: driven data frozen while the driver is on
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R8: no driving in the cycle output enable is released
  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe);

  // R11: never two drivers on the bus
  p_no_fight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [8:0]  wdata = '0;
  logic        ready, rvalid;
  logic [8:0]  rdata;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [8:0]  mem_dq_out;
  logic [8:0]  mem_dq_in = 9'h0A5;

  always #10 clk = !clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Cycle counts restated from the requirements, 20 ns clock.
  function automatic int cyc(real ns);
    return $rtoi($ceil(ns / 20.0));
  endfunction
  localparam int ACC_C = 2;   // access 25 ns
  int RD_C, HZ_C, WZ_C, DRV_C, REC_C, WP_C, DS_C;

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Behavioural memory plus protocol monitor, sampled at falling edges.
  logic [8:0] mem [int];
  logic [8:0] shadow [int];
  logic [12:0] exp_addr = '0, sel_addr = '0;
  int  rd_cnt = 0, we_low = 0, drv_cnt = 0, oe_hi_run = 100, sel_cnt = 0;
  int  v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0, v_r11 = 0;
  bit  p_sel = 0, p_we_n = 1, p_oe_n = 1, p_rd = 0;
  logic [12:0] p_addr = '0;

  always @(negedge clk) begin
    bit sel, rdm;
    if (rst_n) begin
      sel = !mem_ce_n && mem_ce;
      rdm = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && !mem_oe_n) v_r11++;
      if (sel && !p_sel) begin
        sel_cnt++;
        sel_addr = mem_addr;
        if (mem_addr != exp_addr) v_r9++;
      end
      if (sel && p_sel && mem_addr != sel_addr) v_r7++;
      rd_cnt = rdm ? ((p_rd && mem_addr == p_addr) ? rd_cnt + 1 : 1) : 0;
      if (!mem_we_n) begin
        we_low = p_we_n ? 1 : we_low + 1;
        if (mem_dq_oe) begin
          drv_cnt++;
          if (we_low <= WZ_C) v_r5++;
        end
        if (!mem_oe_n) v_r5++;
      end
      if (!p_we_n && mem_we_n) begin
        if (we_low < WP_C || drv_cnt < DS_C) v_r6++;
        if (mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
        else v_r7++;
        drv_cnt = 0;
      end
      if (mem_oe_n) oe_hi_run = (!p_oe_n) ? 1 : ((oe_hi_run < 100) ? oe_hi_run + 1 : 100);
      if (mem_dq_oe && oe_hi_run <= HZ_C) v_r8++;
      if (rdm && rd_cnt >= ACC_C)
        mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 9'h000;
      else
        mem_dq_in = 9'h0A5;
      p_sel = sel; p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_rd = rdm; p_addr = mem_addr;
    end
  end

  // One host operation, started and finished at a falling edge.
  task automatic run_op(input logic w, input logic [12:0] a, input logic [8:0] d);
    int rv_at = 0, rdy_at = 0, rv_n = 0;
    logic [8:0] got = '0, expv;
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; exp_addr = a;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= 40 && rdy_at == 0; k++) begin
      if (rvalid) begin
        rv_n++;
        if (rv_at == 0) begin rv_at = k; got = rdata; end
      end
      if (ready) rdy_at = k;
      else @(negedge clk);
    end
    if (w) begin
      shadow[int'(a)] = d;
      chk(rdy_at == WZ_C + DRV_C + 1 + REC_C + 1, "R10 write busy", rdy_at, WZ_C + DRV_C + REC_C + 2);
    end else begin
      expv = shadow.exists(int'(a)) ? shadow[int'(a)] : 9'h000;
      chk(rv_at == RD_C + 1, "R4 rvalid latency", rv_at, RD_C + 1);
      chk(rv_n == 1, "R4 rvalid single pulse", rv_n, 1);
      chk(got == expv, "R3 read word", int'(got), int'(expv));
      chk(rdy_at == RD_C + HZ_C + 1, "R8 read busy", rdy_at, RD_C + HZ_C + 1);
    end
  endtask

  // {wr, addr[12:0], data[8:0]}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 13'h0000, 9'h1FF}, {1'b1, 13'h1FFF, 9'h0AB}, {1'b0, 13'h0000, 9'h000},
    {1'b0, 13'h1FFF, 9'h000}, {1'b1, 13'h0000, 9'h000}, {1'b0, 13'h0000, 9'h000},
    {1'b1, 13'h0ABC, 9'h155}, {1'b0, 13'h0ABC, 9'h000}, {1'b0, 13'h1234, 9'h000},
    {1'b1, 13'h1234, 9'h0FF}, {1'b0, 13'h1234, 9'h000}, {1'b0, 13'h1FFF, 9'h000}
  };

  initial begin
    int s0;
    RD_C  = (cyc(25.0) > 1) ? cyc(25.0) : 1;
    HZ_C  = cyc(12.0);
    WZ_C  = (cyc(10.0) > 1) ? cyc(10.0) : 1;
    WP_C  = cyc(18.0);
    DS_C  = cyc(13.0);
    DRV_C = DS_C;
    if (WP_C - WZ_C > DRV_C) DRV_C = WP_C - WZ_C;
    if (DRV_C < 1) DRV_C = 1;
    REC_C = cyc(25.0) - (WZ_C + DRV_C + 1);
    if (REC_C < 0) REC_C = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(mem_ce_n == 1'b1, "R1 ce_n parked", mem_ce_n, 1);
    chk(mem_ce == 1'b0, "R1 ce parked", mem_ce, 0);
    chk(mem_oe_n == 1'b1, "R1 oe_n parked", mem_oe_n, 1);
    chk(mem_we_n == 1'b1, "R1 we_n parked", mem_we_n, 1);
    chk(mem_dq_oe == 1'b0, "R1 driver off", mem_dq_oe, 0);
    chk(rvalid == 1'b0, "R4 no strobe in reset", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_op(VEC[i][22], VEC[i][21:9], VEC[i][8:0]);

    // R2: a req pulse while busy must start nothing
    s0 = sel_cnt;
    req = 1'b1; wr = 1'b1; addr = 13'h0777; wdata = 9'h111; exp_addr = 13'h0777;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 13'h0555; wdata = 9'h1AA;
    @(negedge clk);
    req = 1'b0;
    shadow[32'h0777] = 9'h111;
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sel_cnt == s0 + 1, "R2 busy request ignored", sel_cnt, s0 + 1);
    run_op(1'b0, 13'h0555, 9'h000);
    run_op(1'b0, 13'h0777, 9'h000);

    // R8: read followed at once by write, then back-to-back reads
    run_op(1'b0, 13'h0ABC, 9'h000);
    run_op(1'b1, 13'h0ABD, 9'h0C3);
    run_op(1'b0, 13'h0ABD, 9'h000);

    chk(v_r5 == 0, "R5 drive after release wait", v_r5, 0);
    chk(v_r6 == 0, "R6 pulse and setup length", v_r6, 0);
    chk(v_r7 == 0, "R7 address/data hold", v_r7, 0);
    chk(v_r8 == 0, "R8 turnaround respected", v_r8, 0);
    chk(v_r9 == 0, "R9 address valid at select", v_r9, 0);
    chk(v_r11 == 0, "R11 no bus fight", v_r11, 0);
    chk(ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 parked at end", 0, 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule